// File: doc/BRIEF.md
# Command/Address Parity Register

This block is a one-stage pipeline register placed between a memory controller and a two-rank DRAM array. On every rising clock edge it captures the row/column address, bank bits, the three active-low command strobes, the per-rank active-low chip selects, and the per-rank clock-enable and termination-enable bits. It presents all of them, registered, on the DRAM side one cycle later. At the same edge it checks even parity across the address, bank and command strobes together with a parity input bit.

The register also has a small file of control words of its own, which it exposes as a flat configuration bus. A cycle in which every chip select is low and all three command strobes are low is treated as a control-word write. It is not passed to the DRAM: all output chip selects are driven high. The write is applied only when parity is good. A bad-parity DRAM command is still forwarded unchanged.

Every captured cycle is classified into one of five states, and the state register drives the error output. The states are `CAP_IDLE` (no chip select low), `CAP_CMD_OK`, `CAP_CMD_BAD`, `CAP_CW_OK` and `CAP_CW_BAD`. Any state can move to any other state on the next edge, chosen only by the newly captured inputs:
- all chip selects low with a mode-register command goes to `CAP_CW_OK` or `CAP_CW_BAD`, by parity;
- otherwise, any chip select low goes to `CAP_CMD_OK` or `CAP_CMD_BAD`, by parity;
- otherwise the next state is `CAP_IDLE`.

The error output is low exactly while the state is `CAP_CMD_BAD` or `CAP_CW_BAD`.

Top module: `ca_parity_reg`

## Requirements
- R1: While reset is high, the address, bank, the three command strobes, the clock-enable bits and the termination-enable bits captured at a rising edge appear unchanged on the DRAM-side outputs after that edge and hold until the next edge.
- R2: Outside control-word writes, chip-select bit i (active low, rank i) is forwarded to output chip-select bit i one cycle after capture.
- R3: Parity is good when the count of ones across the 16 address bits, 3 bank bits, the three command strobes and the parity input (23 bits in all) is even.
- R4: The active-low error output is low for exactly the one cycle following the capture of a selected cycle with bad parity, and high after every other capture, including the cycle right after an error.
- R5: A cycle with every chip select high never drives the error output low, whatever its parity.
- R6: A DRAM command with bad parity is still forwarded with every field unchanged.
- R7: A control-word write is a cycle with all chip selects low and all three command strobes low. Its index is {bank[2], addr[2:0]} and its 4-bit data is addr[6:3]. After the capturing edge, the data appears on bits [4*index+3 : 4*index] of the control-word bus.
- R8: A control-word write with bad parity leaves every control word unchanged and drives the error output low for one cycle.
- R9: During a control-word write, all output chip selects are high; the other fields are still forwarded.
- R10: While the asynchronous active-low reset is asserted, the following outputs take these values:
  - address, bank, clock-enable and termination-enable are 0;
  - all three command strobes are 1;
  - all chip selects are 1;
  - the error output is 1;
  - every control word is 0.
- R11: A mode-register command with only one chip select low is a DRAM command to that rank. It does not change any control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ca_addr | input | 16 | Address from the controller |
| ca_bank | input | 3 | Bank bits from the controller |
| ca_ras_n | input | 1 | Row strobe, active low |
| ca_cas_n | input | 1 | Column strobe, active low |
| ca_we_n | input | 1 | Write strobe, active low |
| ca_cs_n | input | 2 | Per-rank chip select, active low |
| ca_cke | input | 2 | Per-rank clock enable |
| ca_odt | input | 2 | Per-rank termination enable |
| ca_par | input | 1 | Even-parity bit for address, bank and strobes |
| dr_addr | output | 16 | Registered address to the DRAM |
| dr_bank | output | 3 | Registered bank bits |
| dr_ras_n | output | 1 | Registered row strobe |
| dr_cas_n | output | 1 | Registered column strobe |
| dr_we_n | output | 1 | Registered write strobe |
| dr_cs_n | output | 2 | Registered per-rank chip select |
| dr_cke | output | 2 | Registered per-rank clock enable |
| dr_odt | output | 2 | Registered per-rank termination enable |
| perr_n | output | 1 | Parity error, active low, one cycle per failing capture |
| cw_words | output | 64 | Sixteen 4-bit control words, word k at bits [4k+3:4k] |

## Verification
The hardest case to reach from the ports is a control-word write with bad parity aimed at an index that already holds known non-zero data. If the target word were still zero, a dropped write could not be told apart from an applied one. The stimulus therefore first writes a word with good parity. It then repeats the write to the same index with different data and a flipped parity bit. Single-rank mode-register commands and deselected bad-parity cycles are mixed in next to these writes, so that the write decode and the error gating are each shown to depend on all of their conditions.

// File: rtl/ca_parity_pkg.sv
package ca_parity_pkg;

    // Classification of the most recently captured cycle
    typedef enum logic [2:0] {
        CAP_IDLE    = 3'd0,
        CAP_CMD_OK  = 3'd1,
        CAP_CMD_BAD = 3'd2,
        CAP_CW_OK   = 3'd3,
        CAP_CW_BAD  = 3'd4
    } cap_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_t;

endpackage

// File: rtl/ca_parity_tree.sv
// Odd-count detector: a ripple of XOR stages, one per input bit
module ca_parity_tree #(
    parameter int W = 23
) (
    input  logic [W-1:0] vec,
    output logic         odd
);
    logic [W:0] acc;

    assign acc[0] = 1'b0;
    for (genvar i = 0; i < W; i++) begin : g_stage
        assign acc[i+1] = acc[i] ^ vec[i];
    end
    assign odd = acc[W];
endmodule

// File: rtl/ca_cycle_decode.sv
// Next-state decode: classifies the cycle on the inputs
module ca_cycle_decode
    import ca_parity_pkg::*;
#(
    parameter int NRANK = 2
) (
    input  logic [NRANK-1:0] cs_n,
    input  cmd_t             cmd,
    input  logic             odd,
    output cap_state_e       nxt
);
    logic all_sel;
    logic any_sel;
    logic mrs;

    always_comb begin
        all_sel = (cs_n == '0);
        any_sel = ~(&cs_n);
        mrs     = ~cmd.ras_n & ~cmd.cas_n & ~cmd.we_n;
        if (all_sel && mrs)
            nxt = odd ? CAP_CW_BAD : CAP_CW_OK;
        else if (any_sel)
            nxt = odd ? CAP_CMD_BAD : CAP_CMD_OK;
        else
            nxt = CAP_IDLE;
    end
endmodule

// File: rtl/ca_cw_file.sv
// Control-word storage, one register per index
module ca_cw_file #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [(1<<IDX_W)*DATA_W-1:0]  words
);
    localparam int NW = 1 << IDX_W;

    for (genvar k = 0; k < NW; k++) begin : g_word
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && (wr_idx == IDX_W'(k)))
                q <= wr_data;
        end
        assign words[k*DATA_W +: DATA_W] = q;
    end
endmodule

// File: rtl/ca_parity_reg.sv
module ca_parity_reg
    import ca_parity_pkg::*;
#(
    parameter int AW       = 16,
    parameter int BW       = 3,
    parameter int NRANK    = 2,
    parameter int CW_IDX_W = 4,
    parameter int CW_DW    = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [AW-1:0]                   ca_addr,
    input  logic [BW-1:0]                   ca_bank,
    input  logic                            ca_ras_n,
    input  logic                            ca_cas_n,
    input  logic                            ca_we_n,
    input  logic [NRANK-1:0]                ca_cs_n,
    input  logic [NRANK-1:0]                ca_cke,
    input  logic [NRANK-1:0]                ca_odt,
    input  logic                            ca_par,
    output logic [AW-1:0]                   dr_addr,
    output logic [BW-1:0]                   dr_bank,
    output logic                            dr_ras_n,
    output logic                            dr_cas_n,
    output logic                            dr_we_n,
    output logic [NRANK-1:0]                dr_cs_n,
    output logic [NRANK-1:0]                dr_cke,
    output logic [NRANK-1:0]                dr_odt,
    output logic                            perr_n,
    output logic [(1<<CW_IDX_W)*CW_DW-1:0]  cw_words
);
    localparam int PAR_W = AW + BW + 4;

    cap_state_e           state;
    cap_state_e           nxt;
    cmd_t                 cmd_in;
    logic                 odd;
    logic [CW_IDX_W-1:0]  cw_idx;
    logic [CW_DW-1:0]     cw_data;
    logic                 cw_wr;

    assign cmd_in  = '{ras_n: ca_ras_n, cas_n: ca_cas_n, we_n: ca_we_n};
    assign cw_idx  = {ca_bank[BW-1], ca_addr[CW_IDX_W-2:0]};
    assign cw_data = ca_addr[CW_IDX_W-1 +: CW_DW];
    assign cw_wr   = (nxt == CAP_CW_OK);

    ca_parity_tree #(.W(PAR_W)) u_tree (
        .vec ({ca_addr, ca_bank, ca_ras_n, ca_cas_n, ca_we_n, ca_par}),
        .odd (odd)
    );

    ca_cycle_decode #(.NRANK(NRANK)) u_dec (
        .cs_n (ca_cs_n),
        .cmd  (cmd_in),
        .odd  (odd),
        .nxt  (nxt)
    );

    ca_cw_file #(.IDX_W(CW_IDX_W), .DATA_W(CW_DW)) u_cw (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cw_wr),
        .wr_idx  (cw_idx),
        .wr_data (cw_data),
        .words   (cw_words)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CAP_IDLE;
        else        state <= nxt;
    end

    // Registered forwarding path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dr_addr  <= '0;
            dr_bank  <= '0;
            dr_ras_n <= 1'b1;
            dr_cas_n <= 1'b1;
            dr_we_n  <= 1'b1;
            dr_cs_n  <= '1;
            dr_cke   <= '0;
            dr_odt   <= '0;
        end else begin
            dr_addr  <= ca_addr;
            dr_bank  <= ca_bank;
            dr_ras_n <= ca_ras_n;
            dr_cas_n <= ca_cas_n;
            dr_we_n  <= ca_we_n;
            dr_cke   <= ca_cke;
            dr_odt   <= ca_odt;
            unique case (nxt)
                CAP_CW_OK, CAP_CW_BAD:                dr_cs_n <= '1;
                CAP_IDLE, CAP_CMD_OK, CAP_CMD_BAD:    dr_cs_n <= ca_cs_n;
                default:                              dr_cs_n <= '1;
            endcase
        end
    end

    // Error output from the state
    always_comb begin
        unique case (state)
            CAP_CMD_BAD, CAP_CW_BAD:            perr_n = 1'b0;
            CAP_IDLE, CAP_CMD_OK, CAP_CW_OK:    perr_n = 1'b1;
            default:                            perr_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/ca_parity_reg_chk.sv
module ca_parity_reg_chk #(
    parameter int AW       = 16,
    parameter int BW       = 3,
    parameter int NRANK    = 2,
    parameter int CW_IDX_W = 4,
    parameter int CW_DW    = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [AW-1:0]                   ca_addr,
    input logic [BW-1:0]                   ca_bank,
    input logic                            ca_ras_n,
    input logic                            ca_cas_n,
    input logic                            ca_we_n,
    input logic [NRANK-1:0]                ca_cs_n,
    input logic [NRANK-1:0]                ca_cke,
    input logic [NRANK-1:0]                ca_odt,
    input logic                            ca_par,
    input logic [AW-1:0]                   dr_addr,
    input logic [BW-1:0]                   dr_bank,
    input logic                            dr_ras_n,
    input logic                            dr_cas_n,
    input logic                            dr_we_n,
    input logic [NRANK-1:0]                dr_cs_n,
    input logic [NRANK-1:0]                dr_cke,
    input logic [NRANK-1:0]                dr_odt,
    input logic                            perr_n,
    input logic [(1<<CW_IDX_W)*CW_DW-1:0]  cw_words
);
    logic in_odd;
    logic in_sel;
    logic in_cw;

    assign in_odd = ^{ca_addr, ca_bank, ca_ras_n, ca_cas_n, ca_we_n, ca_par};
    assign in_sel = ~(&ca_cs_n);
    assign in_cw  = (ca_cs_n == '0) && !ca_ras_n && !ca_cas_n && !ca_we_n;

    p_fwd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> {dr_addr, dr_bank, dr_ras_n, dr_cas_n, dr_we_n, dr_cke, dr_odt}
                 == $past({ca_addr, ca_bank, ca_ras_n, ca_cas_n, ca_we_n, ca_cke, ca_odt}));

    p_cs_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_cw |=> dr_cs_n == $past(ca_cs_n));

    p_err_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sel && in_odd) |=> !perr_n);

    p_err_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_sel && in_odd) |=> perr_n);

    p_desel_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (&ca_cs_n) |=> perr_n);

    p_cw_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cw && in_odd) |=> $stable(cw_words));

    p_cw_desel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_cw |=> (&dr_cs_n));

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_r10: assert (perr_n && (&dr_cs_n) && (cw_words == '0)
                                 && (dr_addr == '0) && dr_ras_n && dr_cas_n && dr_we_n);
        end
    end
endmodule

bind ca_parity_reg ca_parity_reg_chk #(
    .AW(AW), .BW(BW), .NRANK(NRANK), .CW_IDX_W(CW_IDX_W), .CW_DW(CW_DW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ca_addr(ca_addr), .ca_bank(ca_bank),
    .ca_ras_n(ca_ras_n), .ca_cas_n(ca_cas_n), .ca_we_n(ca_we_n),
    .ca_cs_n(ca_cs_n), .ca_cke(ca_cke), .ca_odt(ca_odt), .ca_par(ca_par),
    .dr_addr(dr_addr), .dr_bank(dr_bank), .dr_ras_n(dr_ras_n),
    .dr_cas_n(dr_cas_n), .dr_we_n(dr_we_n), .dr_cs_n(dr_cs_n),
    .dr_cke(dr_cke), .dr_odt(dr_odt), .perr_n(perr_n), .cw_words(cw_words)
);

// File: tb/ca_parity_reg_bench.sv
module ca_parity_reg_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] ca_addr;
    logic [2:0]  ca_bank;
    logic        ca_ras_n, ca_cas_n, ca_we_n;
    logic [1:0]  ca_cs_n, ca_cke, ca_odt;
    logic        ca_par;
    logic [15:0] dr_addr;
    logic [2:0]  dr_bank;
    logic        dr_ras_n, dr_cas_n, dr_we_n;
    logic [1:0]  dr_cs_n, dr_cke, dr_odt;
    logic        perr_n;
    logic [63:0] cw_words;

    int checks = 0;
    int fails  = 0;

    // reference model state
    logic [25:0] e_data;
    logic [1:0]  e_cs;
    logic        e_perr;
    logic [3:0]  cw_m [16];
    bit          t_bad, t_cw, t_sel, t_one_mrs, t_prev_low;

    always #(CLK_PERIOD/2) clk = ~clk;

    ca_parity_reg u_ca_parity_reg (
        .clk(clk), .rst_n(rst_n), .ca_addr(ca_addr), .ca_bank(ca_bank),
        .ca_ras_n(ca_ras_n), .ca_cas_n(ca_cas_n), .ca_we_n(ca_we_n),
        .ca_cs_n(ca_cs_n), .ca_cke(ca_cke), .ca_odt(ca_odt), .ca_par(ca_par),
        .dr_addr(dr_addr), .dr_bank(dr_bank), .dr_ras_n(dr_ras_n),
        .dr_cas_n(dr_cas_n), .dr_we_n(dr_we_n), .dr_cs_n(dr_cs_n),
        .dr_cke(dr_cke), .dr_odt(dr_odt), .perr_n(perr_n), .cw_words(cw_words)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [63:0] cw_flat();
        logic [63:0] v;
        for (int k = 0; k < 16; k++) v[k*4 +: 4] = cw_m[k];
        return v;
    endfunction

    // count of ones over the parity-covered inputs, without the parity bit
    function automatic int ones_cnt(logic [15:0] a, logic [2:0] b, logic r, logic c, logic w);
        int n = 0;
        for (int i = 0; i < 16; i++) n += a[i];
        for (int i = 0; i < 3; i++)  n += b[i];
        n += r + c + w;
        return n;
    endfunction

    function automatic logic good_par(logic [15:0] a, logic [2:0] b, logic r, logic c, logic w);
        return logic'(ones_cnt(a, b, r, c, w) % 2);
    endfunction

    task automatic model_reset();
        e_data = {16'h0, 3'h0, 3'b111, 2'b00, 2'b00};
        e_cs = 2'b11; e_perr = 1'b1; t_prev_low = 0;
        for (int k = 0; k < 16; k++) cw_m[k] = 4'h0;
    endtask

    task automatic check_reset();
        check("R10 data",  {38'h0, dr_addr, dr_bank, dr_ras_n, dr_cas_n, dr_we_n, dr_cke, dr_odt},
              {38'h0, 16'h0, 3'h0, 3'b111, 2'b00, 2'b00});
        check("R10 cs",    {62'h0, dr_cs_n}, 64'h3);
        check("R10 perr",  {63'h0, perr_n}, 64'h1);
        check("R10 words", cw_words, 64'h0);
    endtask

    // Apply one cycle at a falling edge, update the model after the
    // capturing edge, then compare at the following falling edge.
    task automatic step(input logic [15:0] a, input logic [2:0] b, input logic r,
                        input logic c, input logic w, input logic [1:0] cs,
                        input logic [1:0] ck, input logic [1:0] od, input logic p);
        int n;
        string tg;
        ca_addr = a; ca_bank = b; ca_ras_n = r; ca_cas_n = c; ca_we_n = w;
        ca_cs_n = cs; ca_cke = ck; ca_odt = od; ca_par = p;
        @(posedge clk);
        #1;
        n = ones_cnt(a, b, r, c, w) + p;
        t_bad = (n % 2) == 1;
        t_sel = cs != 2'b11;
        t_cw  = (cs == 2'b00) && !r && !c && !w;
        t_one_mrs = (cs == 2'b01 || cs == 2'b10) && !r && !c && !w;
        t_prev_low = !e_perr;
        e_data = {a, b, r, c, w, ck, od};
        e_cs   = t_cw ? 2'b11 : cs;
        e_perr = !(t_sel && t_bad);
        if (t_cw && !t_bad) cw_m[{b[2], a[2:0]}] = a[6:3];
        @(negedge clk);
        check(t_bad ? "R6 forward" : "R1 forward",
              {38'h0, dr_addr, dr_bank, dr_ras_n, dr_cas_n, dr_we_n, dr_cke, dr_odt},
              {38'h0, e_data});
        check(t_cw ? "R9 cs" : "R2 cs", {62'h0, dr_cs_n}, {62'h0, e_cs});
        if (!t_sel)          tg = "R5 perr";
        else if (t_prev_low) tg = "R4 perr";
        else                 tg = "R3 perr";
        check(tg, {63'h0, perr_n}, {63'h0, e_perr});
        if (t_one_mrs)            tg = "R11 words";
        else if (t_cw && t_bad)   tg = "R8 words";
        else                      tg = "R7 words";
        check(tg, cw_words, cw_flat());
    endtask

    task automatic cw_write(input int idx, input logic [3:0] d, input bit corrupt);
        logic [15:0] a;
        logic [2:0]  b;
        a = {9'h0, d, 3'(idx)};
        b = {1'(idx >> 3), 2'b01};
        step(a, b, 1'b0, 1'b0, 1'b0, 2'b00, 2'b11, 2'b01,
             good_par(a, b, 1'b0, 1'b0, 1'b0) ^ corrupt);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b1;
        ca_addr = '0; ca_bank = '0; ca_ras_n = 1; ca_cas_n = 1; ca_we_n = 1;
        ca_cs_n = 2'b11; ca_cke = 0; ca_odt = 0; ca_par = 0;
        #1 rst_n = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        check_reset();                                 // R10
        rst_n = 1'b1;

        // random traffic: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            logic [2:0]  b;
            logic [2:0]  cm;
            a  = 16'($urandom);
            b  = 3'($urandom);
            cm = 3'($urandom);
            step(a, b, cm[2], cm[1], cm[0], 2'($urandom), 2'($urandom), 2'($urandom),
                 1'($urandom));
        end

        // bad-parity read to rank 0 still forwarded (R6), then good (R4)
        step(16'h1234, 3'h5, 1'b1, 1'b0, 1'b1, 2'b10, 2'b11, 2'b01,
             ~good_par(16'h1234, 3'h5, 1'b1, 1'b0, 1'b1));
        step(16'h1234, 3'h5, 1'b1, 1'b0, 1'b1, 2'b10, 2'b11, 2'b01,
             good_par(16'h1234, 3'h5, 1'b1, 1'b0, 1'b1));

        // control-word writes at both index ends and the middle (R7)
        cw_write(0, 4'h9, 0);
        cw_write(15, 4'hF, 0);
        cw_write(5, 4'hA, 0);
        // corrupted overwrite of a non-zero word is dropped (R8)
        cw_write(5, 4'h3, 1);
        cw_write(15, 4'h1, 1);
        // mode-register command to one rank only is not a control write (R11)
        step(16'h0035, 3'h1, 1'b0, 1'b0, 1'b0, 2'b10, 2'b11, 2'b00,
             good_par(16'h0035, 3'h1, 1'b0, 1'b0, 1'b0));
        step(16'h0035, 3'h1, 1'b0, 1'b0, 1'b0, 2'b01, 2'b11, 2'b00,
             good_par(16'h0035, 3'h1, 1'b0, 1'b0, 1'b0));
        // deselected cycle with bad parity raises nothing (R5)
        step(16'hFFFF, 3'h7, 1'b0, 1'b1, 1'b0, 2'b11, 2'b00, 2'b00,
             ~good_par(16'hFFFF, 3'h7, 1'b0, 1'b1, 1'b0));
        // back-to-back bad commands then good (R4)
        step(16'h00F0, 3'h2, 1'b0, 1'b1, 1'b1, 2'b01, 2'b10, 2'b10,
             ~good_par(16'h00F0, 3'h2, 1'b0, 1'b1, 1'b1));
        step(16'h00F1, 3'h2, 1'b0, 1'b1, 1'b1, 2'b01, 2'b10, 2'b10,
             ~good_par(16'h00F1, 3'h2, 1'b0, 1'b1, 1'b1));
        step(16'h00F2, 3'h2, 1'b0, 1'b1, 1'b1, 2'b01, 2'b10, 2'b10,
             good_par(16'h00F2, 3'h2, 1'b0, 1'b1, 1'b1));

        // mid-run reset clears control words (R10)
        rst_n = 1'b0;
        model_reset();
        #2;
        check_reset();
        @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        cw_write(7, 4'h6, 0);                          // R7 after reset

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule